// File: doc/BRIEF.md
# Predicated-Skip Writeback Controller

This block handles predication in a short, in-order pipeline. It does not keep shadow copies of registers. Instead it cancels register writeback. A predicate word enters the issue stream ahead of the instructions it guards. That word picks one condition flag of one register in one of the two globules, and can invert it. It also opens a shadow window that covers the next one to eight issued instructions. The block captures the chosen flag when the window opens. Each data instruction inside the window then gets a write-enable gate that equals the captured condition. Instructions outside any window write back normally.

The window has two hard limits. It may guard at most four ALU operations, and it may contain no control word. An instruction that breaks either limit is flagged as an illegal predication. Its writeback is blocked and the window closes at once. The gate and error results leave the block at a fixed writeback latency, lined up with each issued instruction.

Top module: `pred_wb_ctrl`

## Requirements
- R1: While reset is held, and in the first two cycles after it, `wb_valid_o`, `wb_keep_o` and `wb_err_o` are 0. Reset also closes any open window.
- R2: Each issue cycle with `issue_valid_i`=1 shows up on the writeback outputs exactly two clock edges later with `wb_valid_o`=1. An instruction outside any window gets `wb_keep_o`=1 and `wb_err_o`=0. Bubbles come out with all three outputs at 0.
- R3: The issue kind is coded as 0 = ALU op, 1 = non-ALU data op, 2 = control word, 3 = predicate word. A predicate word issued while no window is open gets `wb_keep_o`=1. It opens a window over the next `pred_desc_i[11:9]`+1 valid issues. Bubbles are not counted.
- R4: The descriptor fields are: globule select `pred_desc_i[0]`, register index `pred_desc_i[4:1]`, flag select `pred_desc_i[7:5]`, and invert `pred_desc_i[8]`. The flags of globule g, register r sit at `flags_i[(g*16+r)*5 +: 5]`, ordered as bit0 LSB0, bit1 LSB1, bit2 LSB2, bit3 MSB, bit4 Zero. Flag select values 0 to 4 pick those bits. Values 5 to 7 mean always true. The condition is the picked flag XOR invert.
- R5: When the condition is false, ALU ops and non-ALU data ops inside the window get `wb_keep_o`=0. When it is true, they get `wb_keep_o`=1.
- R6: The condition is sampled in the predicate word's issue cycle. Changes to `flags_i` later in the window do not change any gate.
- R7: A fifth ALU op inside one window gets `wb_err_o`=1 and `wb_keep_o`=0, and it closes the window.
- R8: A control word or predicate word inside an open window gets `wb_err_o`=1 and `wb_keep_o`=0. It closes the window and does not open a new one.
- R9: Once the window's length is used up, the next instruction writes back normally, whatever the condition was.
- R10: Non-ALU data ops use up window length but do not count toward the ALU limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_valid_i | input | 1 | An instruction issues this cycle |
| issue_kind_i | input | 2 | Issue kind: 0 ALU, 1 data op, 2 control, 3 predicate |
| pred_desc_i | input | 12 | Predicate descriptor, sampled with a predicate word |
| flags_i | input | 160 | Condition flags for every register of both globules |
| wb_valid_o | output | 1 | An issued instruction reaches writeback |
| wb_keep_o | output | 1 | Register write enable gate for that instruction |
| wb_err_o | output | 1 | Illegal predication for that instruction |

## Verification
The stimulus changes the selected flag right after a window opens. A design that reads the flag live, instead of capturing it at the open, would flip the gates. Bubbles are placed inside windows, so a design that counts them would end the window early and let a suppressed data op write. The bench also drives a fifth ALU op, a control word inside a window, and a predicate word inside a window. A design that got any of these wrong would either miss the error or leave the window open, and the next instruction would then be cancelled wrongly. It also reads a flag from globule 0 while globule 1 holds the opposite value, uses the always-true flag selects with inversion, and applies reset in the middle of a window. A design that mixed up globules, ignored inversion or kept a stale window would show the wrong gate value.

// File: rtl/ps_pkg.sv
package ps_pkg;
  localparam int NUM_GLOB = 2;
  localparam int NUM_REG  = 16;
  localparam int FLAG_W   = 5;
  localparam int GLOB_W   = $clog2(NUM_GLOB);
  localparam int RIDX_W   = $clog2(NUM_REG);
  localparam int LEN_W    = 3;
  localparam int FSEL_W   = 3;
  localparam int DESC_W   = LEN_W + 1 + FSEL_W + RIDX_W + GLOB_W;
  localparam int FLAGS_W  = NUM_GLOB * NUM_REG * FLAG_W;

  typedef enum logic [1:0] {
    K_ALU  = 2'd0,
    K_DATA = 2'd1,
    K_CTRL = 2'd2,
    K_PRED = 2'd3
  } kind_e;

  typedef enum logic [FSEL_W-1:0] {
    F_LSB0 = 3'd0,
    F_LSB1 = 3'd1,
    F_LSB2 = 3'd2,
    F_MSB  = 3'd3,
    F_ZERO = 3'd4
  } fsel_e;

  typedef struct packed {
    logic [LEN_W-1:0]  len_m1;
    logic              inv;
    logic [FSEL_W-1:0] fsel;
    logic [RIDX_W-1:0] ridx;
    logic [GLOB_W-1:0] gsel;
  } pdesc_t;
endpackage

// File: rtl/flag_pick.sv
module flag_pick
  import ps_pkg::*;
(
  input  logic [FLAGS_W-1:0] flags_i,
  input  logic [GLOB_W-1:0]  gsel_i,
  input  logic [RIDX_W-1:0]  ridx_i,
  input  logic [FSEL_W-1:0]  fsel_i,
  output logic               flag_o
);
  localparam int N_ENT = NUM_GLOB * NUM_REG;
  localparam int IDX_W = GLOB_W + RIDX_W;

  logic [FLAG_W-1:0] ent [N_ENT];
  logic [FLAG_W-1:0] picked;
  logic [IDX_W-1:0]  idx;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    assign ent[e] = flags_i[e*FLAG_W +: FLAG_W];
  end

  assign idx    = {gsel_i, ridx_i};
  assign picked = ent[idx];

  always_comb begin
    unique case (fsel_i)
      F_LSB0:  flag_o = picked[0];
      F_LSB1:  flag_o = picked[1];
      F_LSB2:  flag_o = picked[2];
      F_MSB:   flag_o = picked[3];
      F_ZERO:  flag_o = picked[4];
      default: flag_o = 1'b1; // reserved selects act as "always"
    endcase
  end
endmodule

// File: rtl/window_ctl.sv
module window_ctl
  import ps_pkg::*;
#(
  parameter int WIN_MAX = 8,
  parameter int ALU_MAX = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   valid_i,
  input  kind_e  kind_i,
  input  pdesc_t desc_i,
  input  logic   flag_i,
  output logic   keep_o,
  output logic   err_o
);
  localparam int CNT_W = $clog2(WIN_MAX + 1);
  localparam int ALU_W = $clog2(ALU_MAX + 1);

  logic [CNT_W-1:0] rem_q, rem_d;
  logic [ALU_W-1:0] alu_q, alu_d;
  logic             cond_q, cond_d;
  logic             in_win;

  assign in_win = (rem_q != '0);

  always_comb begin
    keep_o = 1'b0;
    err_o  = 1'b0;
    if (valid_i) begin
      if (!in_win) begin
        keep_o = 1'b1;
      end else begin
        unique case (kind_i)
          K_CTRL, K_PRED: err_o = 1'b1;
          K_ALU: begin
            if (alu_q == ALU_W'(ALU_MAX)) err_o = 1'b1;
            else keep_o = cond_q;
          end
          default: keep_o = cond_q;
        endcase
      end
    end
  end

  always_comb begin
    rem_d  = rem_q;
    alu_d  = alu_q;
    cond_d = cond_q;
    if (valid_i) begin
      if (!in_win) begin
        if (kind_i == K_PRED) begin
          rem_d  = CNT_W'(desc_i.len_m1) + CNT_W'(1);
          alu_d  = '0;
          cond_d = flag_i ^ desc_i.inv;
        end
      end else if (err_o) begin
        rem_d = '0;
        alu_d = '0;
      end else begin
        rem_d = rem_q - CNT_W'(1);
        if (kind_i == K_ALU) alu_d = alu_q + ALU_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      alu_q  <= '0;
      cond_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      alu_q  <= alu_d;
      cond_q <= cond_d;
    end
  end

  assert_win_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= CNT_W'(WIN_MAX));

  assert_open_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !in_win && kind_i == K_PRED)
      |=> (rem_q == CNT_W'($past(desc_i.len_m1)) + CNT_W'(1)));

  assert_alu_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_q <= ALU_W'(ALU_MAX));

  assert_ctrl_closes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_win && (kind_i == K_CTRL || kind_i == K_PRED)) |=> (rem_q == '0));

  assert_cond_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win |=> $stable(cond_q));
endmodule

// File: rtl/wb_delay.sv
module wb_delay #(
  parameter int LAT = 2,
  parameter int W   = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [LAT-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < LAT; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[LAT-1];
endmodule

// File: rtl/pred_wb_ctrl.sv
module pred_wb_ctrl
  import ps_pkg::*;
#(
  parameter int WIN_MAX = 8,
  parameter int ALU_MAX = 4,
  parameter int WB_LAT  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_valid_i,
  input  logic [1:0]         issue_kind_i,
  input  logic [DESC_W-1:0]  pred_desc_i,
  input  logic [FLAGS_W-1:0] flags_i,
  output logic               wb_valid_o,
  output logic               wb_keep_o,
  output logic               wb_err_o
);
  pdesc_t desc;
  kind_e  kind;
  logic   flag_sel;
  logic   keep_now, err_now;
  logic [2:0] wb_q;

  assign desc = pdesc_t'(pred_desc_i);
  assign kind = kind_e'(issue_kind_i);

  flag_pick u_pick (
    .flags_i (flags_i),
    .gsel_i  (desc.gsel),
    .ridx_i  (desc.ridx),
    .fsel_i  (desc.fsel),
    .flag_o  (flag_sel)
  );

  window_ctl #(.WIN_MAX(WIN_MAX), .ALU_MAX(ALU_MAX)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (issue_valid_i),
    .kind_i  (kind),
    .desc_i  (desc),
    .flag_i  (flag_sel),
    .keep_o  (keep_now),
    .err_o   (err_now)
  );

  wb_delay #(.LAT(WB_LAT), .W(3)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({issue_valid_i, keep_now, err_now}),
    .q_o    (wb_q)
  );

  assign {wb_valid_o, wb_keep_o, wb_err_o} = wb_q;

  assert_err_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_err_o |-> (wb_valid_o && !wb_keep_o));

  assert_bubble_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_valid_o |-> (!wb_keep_o && !wb_err_o));
endmodule

// File: tb/pred_wb_ctrl_tb_top.sv
module pred_wb_ctrl_tb_top;
  localparam int FW  = 160;
  localparam int FOF = (1*16 + 5) * 5; // globule 1, register 5

  typedef struct packed {
    logic        v;
    logic [1:0]  k;
    logic [11:0] d;
    logic [4:0]  fl;
    logic        ev;
    logic        ek;
    logic        ee;
    logic [3:0]  rq;
  } vec_t;

  function automatic logic [11:0] pd(input logic g, input logic [3:0] r,
                                     input logic [2:0] s, input logic i,
                                     input int len);
    logic [2:0] lm;
    lm = 3'(len - 1);
    return {lm, i, s, r, g};
  endfunction

  localparam logic [11:0] D_A = pd(1'b1, 4'd5, 3'd0, 1'b0, 3); // lsb0, true
  localparam logic [11:0] D_B = pd(1'b1, 4'd5, 3'd3, 1'b0, 2); // msb, false
  localparam logic [11:0] D_C = pd(1'b1, 4'd5, 3'd4, 1'b1, 8); // !zero, false
  localparam logic [11:0] D_D = pd(1'b0, 4'd5, 3'd2, 1'b1, 4); // glob0 !lsb2, true
  localparam logic [11:0] D_E = pd(1'b1, 4'd5, 3'd6, 1'b1, 2); // !always, false
  localparam logic [11:0] D_F = pd(1'b1, 4'd5, 3'd1, 1'b0, 1); // lsb1, false
  localparam logic [11:0] D_G = pd(1'b1, 4'd5, 3'd5, 1'b0, 1); // always, true

  localparam int N = 36;
  localparam vec_t TBL [N] = '{
    '{1'b1, 2'd0, 12'd0, 5'b00000, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 outside
    '{1'b0, 2'd0, 12'd0, 5'b00000, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 bubble
    '{1'b1, 2'd3, D_A,   5'b00001, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 open true
    '{1'b1, 2'd0, 12'd0, 5'b00000, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 flag dropped
    '{1'b0, 2'd0, 12'd0, 5'b00000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 bubble
    '{1'b1, 2'd1, 12'd0, 5'b00000, 1'b1, 1'b1, 1'b0, 4'd5},
    '{1'b1, 2'd0, 12'd0, 5'b00000, 1'b1, 1'b1, 1'b0, 4'd5},
    '{1'b1, 2'd0, 12'd0, 5'b00000, 1'b1, 1'b1, 1'b0, 4'd9},
    '{1'b1, 2'd3, D_B,   5'b00000, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 msb false
    '{1'b1, 2'd0, 12'd0, 5'b01000, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 R6
    '{1'b0, 2'd0, 12'd0, 5'b01000, 1'b0, 1'b0, 1'b0, 4'd3},
    '{1'b1, 2'd1, 12'd0, 5'b01000, 1'b1, 1'b0, 1'b0, 4'd10}, // R10
    '{1'b1, 2'd0, 12'd0, 5'b01000, 1'b1, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b1, 2'd3, D_C,   5'b10000, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 inv zero
    '{1'b1, 2'd0, 12'd0, 5'b10000, 1'b1, 1'b0, 1'b0, 4'd5},
    '{1'b1, 2'd1, 12'd0, 5'b10000, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 no ALU count
    '{1'b1, 2'd0, 12'd0, 5'b10000, 1'b1, 1'b0, 1'b0, 4'd5},
    '{1'b1, 2'd0, 12'd0, 5'b10000, 1'b1, 1'b0, 1'b0, 4'd5},
    '{1'b1, 2'd0, 12'd0, 5'b10000, 1'b1, 1'b0, 1'b0, 4'd5},
    '{1'b1, 2'd0, 12'd0, 5'b10000, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 fifth ALU
    '{1'b1, 2'd0, 12'd0, 5'b10000, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 closed
    '{1'b1, 2'd3, D_D,   5'b00100, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 glob0
    '{1'b1, 2'd0, 12'd0, 5'b00100, 1'b1, 1'b1, 1'b0, 4'd4},
    '{1'b1, 2'd2, 12'd0, 5'b00100, 1'b1, 1'b0, 1'b1, 4'd8},  // R8 ctrl
    '{1'b1, 2'd0, 12'd0, 5'b00100, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 closed
    '{1'b1, 2'd3, D_E,   5'b00000, 1'b1, 1'b1, 1'b0, 4'd4},
    '{1'b1, 2'd3, D_A,   5'b00001, 1'b1, 1'b0, 1'b1, 4'd8},  // R8 pred in win
    '{1'b1, 2'd1, 12'd0, 5'b00001, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 no reopen
    '{1'b1, 2'd3, D_F,   5'b00101, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 lsb1
    '{1'b1, 2'd0, 12'd0, 5'b00101, 1'b1, 1'b0, 1'b0, 4'd5},
    '{1'b1, 2'd0, 12'd0, 5'b00101, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 len 1
    '{1'b1, 2'd3, D_G,   5'b00000, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 always
    '{1'b1, 2'd1, 12'd0, 5'b00000, 1'b1, 1'b1, 1'b0, 4'd4},
    '{1'b1, 2'd2, 12'd0, 5'b00000, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 ctrl outside
    '{1'b0, 2'd0, 12'd0, 5'b00000, 1'b0, 1'b0, 1'b0, 4'd2},
    '{1'b1, 2'd1, 12'd0, 5'b00000, 1'b1, 1'b1, 1'b0, 4'd2}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          issue_valid_i = 1'b0;
  logic [1:0]    issue_kind_i = '0;
  logic [11:0]   pred_desc_i = '0;
  logic [FW-1:0] flags_i = '0;
  logic          wb_valid_o, wb_keep_o, wb_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pred_wb_ctrl dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .issue_valid_i (issue_valid_i),
    .issue_kind_i  (issue_kind_i),
    .pred_desc_i   (pred_desc_i),
    .flags_i       (flags_i),
    .wb_valid_o    (wb_valid_o),
    .wb_keep_o     (wb_keep_o),
    .wb_err_o      (wb_err_o)
  );

  task automatic chk(input string what, input logic act, input logic exp, input int rq);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b", rq, what, act, exp);
    end
  endtask

  task automatic chk3(input logic ev, input logic ek, input logic ee, input int rq);
    chk("wb_valid_o", wb_valid_o, ev, rq);
    chk("wb_keep_o",  wb_keep_o,  ek, rq);
    chk("wb_err_o",   wb_err_o,   ee, rq);
  endtask

  task automatic drive(input logic v, input logic [1:0] k, input logic [11:0] d,
                       input logic [4:0] fl);
    issue_valid_i = v;
    issue_kind_i  = k;
    pred_desc_i   = d;
    flags_i       = '0;
    flags_i[FOF +: 5] = fl;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet in reset, even with issue activity
    drive(1'b1, 2'd0, 12'd0, 5'b00000);
    repeat (3) @(negedge clk_i);
    chk3(1'b0, 1'b0, 1'b0, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk3(1'b0, 1'b0, 1'b0, 1); // only one edge since release
    drive(1'b0, 2'd0, 12'd0, 5'b00000);
    repeat (2) @(negedge clk_i);

    for (int j = 0; j < N + 2; j++) begin
      if (j >= 2) chk3(TBL[j-2].ev, TBL[j-2].ek, TBL[j-2].ee, int'(TBL[j-2].rq));
      if (j < N) drive(TBL[j].v, TBL[j].k, TBL[j].d, TBL[j].fl);
      else       drive(1'b0, 2'd0, 12'd0, 5'b00000);
      @(negedge clk_i);
    end

    // R1: reset inside a false window closes it
    drive(1'b1, 2'd3, D_C, 5'b10000);
    @(negedge clk_i);
    drive(1'b1, 2'd0, 12'd0, 5'b10000);
    @(negedge clk_i);
    drive(1'b0, 2'd0, 12'd0, 5'b10000);
    @(negedge clk_i);
    chk3(1'b1, 1'b0, 1'b0, 5); // shadowed ALU before reset
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk3(1'b0, 1'b0, 1'b0, 1);
    rst_ni = 1'b1;
    drive(1'b1, 2'd0, 12'd0, 5'b10000);
    @(negedge clk_i);
    drive(1'b0, 2'd0, 12'd0, 5'b10000);
    @(negedge clk_i);
    chk3(1'b1, 1'b1, 1'b0, 1); // r1_ window gone after reset

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule